// File: doc/BRIEF.md
# Scaled Monochrome Framebuffer Scanout

This block turns a packed one-bit-per-pixel framebuffer into a serial video bit stream for a display whose resolution is twice the stored width and three times the stored height. Each stored row holds a fixed number of bytes. The leading bytes carry visible pixels and the trailing bytes are padding that fill part of the horizontal blanking interval. The block reads each byte through a synchronous read port and shifts it out most-significant bit first. Every bit is held for two pixel clocks, which doubles the pixels horizontally.

Streaming only starts after vertical timing logic has armed the block with a frame-valid pulse. After that, each line-start strobe, which arrives at the end of horizontal sync plus back porch, streams one whole row. The same row is sent on three consecutive display lines before the row pointer moves on. After the last row has been sent, the block disarms itself and waits for the next frame-valid pulse. Sync generation and colour mapping belong to neighbouring logic.

Top module: `fb_scanout`

## Requirements
- R1: While reset is asserted, and after it is released, `video` is 0 and `mem_addr` is 0. The block is disarmed after reset.
- R2: A `line_start` strobe while the block is disarmed has no effect: `video` stays 0 and `mem_addr` stays at the current row base.
- R3: When a strobe is accepted on a clock edge, the first bit appears on `video` after the second following edge. Each bit is held for exactly two clocks. Bytes are emitted bit 7 first.
- R4: One accepted strobe streams all BYTES bytes of the row, padding included, which is BYTES*16 clocks. After that `video` returns to 0.
- R5: Each row is streamed on REPEAT (3) consecutive accepted lines. Only then does the row base advance by BYTES.
- R6: After the last repetition of row ROWS-1, the row base and the repeat count return to 0 and the block disarms. Later strobes are ignored until a `frame_valid` pulse arrives, and the next accepted line then starts at row 0.
- R7: A `line_start` strobe that arrives while a row is being fetched or streamed is ignored. The current line runs to completion, and the ignored strobe does not count as a repetition.
- R8: In the cycle after a strobe is accepted, `mem_addr` equals the row base. While byte k is on the output, `mem_addr` points at byte k+1 of the same row, and the last byte holds its own address. `mem_addr` never reaches ROWS*BYTES.
- R9: A framebuffer bit of 1 drives `video` high. Whenever no row is streaming, `video` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at the end of sync plus back porch |
| frame_valid | input | 1 | One-cycle pulse that arms streaming for a frame |
| mem_rdata | input | 8 | Byte from the framebuffer, one cycle after its address |
| mem_addr | output | $clog2(BYTES*ROWS) | Framebuffer byte address |
| video | output | 1 | Serial monochrome pixel output |

## Verification
The assertions assume that `mem_rdata` follows `mem_addr` with exactly one cycle of latency. They also assume that strobes are one-cycle pulses, so that a strobe held high could not restart a line on the cycle the previous line ends. The bench's memory model is a registered function of the address, which meets the latency assumption. Every strobe and frame-valid pulse is driven for a single clock. Active lines are spaced far enough apart for each one to finish, except in the one test that deliberately strobes mid-line.

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int BYTES  = 52,
  parameter int ROWS   = 200,
  parameter int REPEAT = 3,
  localparam int AW = $clog2(BYTES * ROWS),
  localparam int BW = $clog2(BYTES),
  localparam int RW = $clog2(ROWS),
  localparam int PW = $clog2(REPEAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          frame_valid,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          video
);

  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_FETCH = 2'd1;
  localparam logic [1:0] S_LOAD  = 2'd2;
  localparam logic [1:0] S_SHIFT = 2'd3;

  logic [1:0]    state;
  logic          armed;
  logic [7:0]    sh;
  logic [2:0]    bitc;
  logic          ph;
  logic [BW-1:0] byte_idx;
  logic [RW-1:0] row;
  logic [PW-1:0] rep;
  logic [AW-1:0] base;

  wire last_byte = (byte_idx == BW'(BYTES - 1));
  wire ahead     = (state == S_LOAD) || (state == S_SHIFT);

  assign mem_addr = base + AW'(byte_idx) + AW'(ahead && !last_byte);
  assign video    = (state == S_SHIFT) & sh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      armed    <= 1'b0;
      sh       <= '0;
      bitc     <= '0;
      ph       <= 1'b0;
      byte_idx <= '0;
      row      <= '0;
      rep      <= '0;
      base     <= '0;
    end else begin
      if (frame_valid) armed <= 1'b1;
      case (state)
        S_IDLE: begin
          byte_idx <= '0;
          if (line_start && armed) state <= S_FETCH;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          sh    <= mem_rdata;
          bitc  <= '0;
          ph    <= 1'b0;
          state <= S_SHIFT;
        end
        default: begin
          ph <= ~ph;
          if (ph) begin
            if (bitc == 3'd7) begin
              bitc <= '0;
              if (last_byte) begin
                state    <= S_IDLE;
                byte_idx <= '0;
                if (rep == PW'(REPEAT - 1)) begin
                  rep <= '0;
                  if (row == RW'(ROWS - 1)) begin
                    row  <= '0;
                    base <= '0;
                    if (!frame_valid) armed <= 1'b0;
                  end else begin
                    row  <= row + 1'b1;
                    base <= base + AW'(BYTES);
                  end
                end else begin
                  rep <= rep + 1'b1;
                end
              end else begin
                byte_idx <= byte_idx + 1'b1;
                sh       <= mem_rdata;
              end
            end else begin
              bitc <= bitc + 1'b1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end
      endcase
    end
  end

endmodule

module fb_scanout_chk #(
  parameter int BYTES  = 52,
  parameter int ROWS   = 200,
  parameter int REPEAT = 3,
  localparam int AW = $clog2(BYTES * ROWS),
  localparam int CW = $clog2(BYTES * 16 + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic [1:0]    state,
  input logic          armed,
  input logic          ph,
  input logic          video,
  input logic [AW-1:0] mem_addr
);

  logic [CW-1:0] shift_cnt;
  logic          was_shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_cnt <= '0;
      was_shift <= 1'b0;
    end else begin
      shift_cnt <= (state == 2'd3) ? shift_cnt + 1'b1 : '0;
      was_shift <= (state == 2'd3);
    end
  end

  a_r2_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !armed) |=> state == 2'd0);

  a_r3_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && !ph) |=> $stable(video));

  a_r4_line_length: assert property (@(posedge clk) disable iff (!rst_n)
    (was_shift && state != 2'd3) |-> shift_cnt == CW'(BYTES * 16));

  a_r6_armed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd0) |-> armed);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && line_start) |=> state != 2'd1);

  a_r8_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mem_addr) < BYTES * ROWS);

endmodule

bind fb_scanout fb_scanout_chk #(.BYTES(BYTES), .ROWS(ROWS), .REPEAT(REPEAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .state(state),
  .armed(armed), .ph(ph), .video(video), .mem_addr(mem_addr)
);

// File: tb/tb_fb_scanout.sv
module tb_fb_scanout;
  localparam int BYTES = 52;
  localparam int ROWS  = 5;
  localparam int REP   = 3;
  localparam int AW    = $clog2(BYTES * ROWS);
  localparam int NV    = 18;

  // {frame_valid pulse, expect active, row}
  localparam logic [7:0] VEC [NV] = '{
    8'h00, 8'hC0, 8'h40, 8'h40, 8'h41, 8'h41, 8'h41, 8'h42, 8'h42,
    8'h42, 8'h43, 8'h43, 8'h43, 8'h44, 8'h44, 8'h44, 8'h00, 8'hC0
  };

  logic clk = 0, rst_n = 0, line_start = 0, frame_valid = 0;
  logic [7:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic video;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  fb_scanout #(.BYTES(BYTES), .ROWS(ROWS), .REPEAT(REP)) dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_valid(frame_valid),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .video(video)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + (a >> 3) + 5);
  endfunction

  always_ff @(posedge clk) mem_rdata <= pat(int'(mem_addr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_line(input bit fv, input bit act, input int row, input int glitch);
    int base, bad;
    base = row * BYTES;
    if (fv) begin
      frame_valid = 1; @(negedge clk); frame_valid = 0;
    end
    line_start = 1; @(negedge clk); line_start = 0;
    if (!act) begin
      bad = 0;
      for (int c = 0; c < BYTES * 16 + 20; c++) begin
        if (video !== 1'b0 || mem_addr !== '0) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R2/R6 ignored strobe", bad, 0);
      return;
    end
    chk(int'(mem_addr) == base, "R8 fetch addr", int'(mem_addr), base);
    @(negedge clk);
    chk(int'(mem_addr) == base + 1, "R8 load addr", int'(mem_addr), base + 1);
    chk(video == 1'b0, "R9 black before data", int'(video), 0);
    @(negedge clk);
    for (int n = 0; n < BYTES * 8; n++) begin
      for (int h = 0; h < 2; h++) begin
        logic [7:0] b;
        int ea;
        line_start = (glitch == n * 2 + h);
        b = pat(base + n / 8);
        chk(video == b[7 - n % 8], "R3/R5 pixel", int'(video), int'(b[7 - n % 8]));
        if (h == 0 && n % 8 == 0) begin
          ea = base + ((n / 8 == BYTES - 1) ? n / 8 : n / 8 + 1);
          chk(int'(mem_addr) == ea, "R8 prefetch addr", int'(mem_addr), ea);
        end
        @(negedge clk);
      end
    end
    line_start = 0;
    chk(video == 1'b0, "R4 black after line", int'(video), 0);
    repeat (20) @(negedge clk);
    chk(video == 1'b0, "R9 idle black", int'(video), 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(video == 1'b0, "R1 reset video", int'(video), 0);
    chk(mem_addr == '0, "R1 reset addr", int'(mem_addr), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(video == 1'b0 && mem_addr == '0, "R1 after reset", int'(mem_addr), 0);

    for (int i = 0; i < NV; i++)
      do_line(VEC[i][7], VEC[i][6], int'(VEC[i][5:0]), -1);

    // R7: mid-line strobe ignored, line completes, repetition count unchanged
    do_line(1'b0, 1'b1, 0, 300);
    do_line(1'b0, 1'b1, 0, -1);
    do_line(1'b0, 1'b1, 1, -1);

    finish_sim();
  end
endmodule